// File: doc/BRIEF.md
# Trapezoid Edge Waveform Sequencer

This block produces one DAC code per clock for a fast converter whose output runs through an analog filter into a comparator. It does not approximate a sine. Each period is a trapezoid with a staircase rising edge, a high plateau, a staircase falling edge and a low plateau. Each edge takes a fixed number of evenly spaced steps, so the comparator sees a steep, repeatable crossing whatever the repetition rate.

The plateau lengths and the two levels come in on plain inputs. They are captured once per period, on the clock edge where the rising staircase begins, and a one-cycle marker on that same edge flags the start of the period. Inputs that change while a period is running act only from the next period. When enable is low, the block parks the output on the low level input. When enable returns, a new period starts from the code that is being shown.

Top module: `trap_edge_seq`

## Requirements
- R1: With enable high, the segments repeat in the order rising edge, high plateau, falling edge, low plateau. The first code after enable rises, or after a low plateau ends, is step 1 of a rising edge.
- R2: The high plateau shows the captured high level for exactly high_len+1 cycles, so a length of 0 still gives one cycle.
- R3: The low plateau shows the captured low level for exactly low_len+1 cycles.
- R4: Edge step k (k = 1..STEPS, STEPS = 16 by default) outputs from + trunc((to-from)*k/STEPS), where the division truncates toward zero. Step STEPS therefore equals the destination level exactly, and step 1 differs from the start level whenever the two levels differ by STEPS or more.
- R5: The four settings are sampled only on the clock edge that outputs rising step 1. Changes at any other time do not affect the period in progress. A rising edge starts from the low level of the previous period, or from the code shown while idle.
- R6: rise_start is 1 for exactly the cycle that shows rising step 1, and 0 in every other cycle.
- R7: On every clock edge where enable is low, dac_code takes the low_code value present at that edge and rise_start is 0.
- R8: While reset is asserted, dac_code is 0 and rise_start is 0.
- R9: If the high level is below the low level, the same formula applies: the rising edge steps downward and the falling edge steps upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the waveform; low parks the output on low_code |
| high_len | input | LEN_W (16) | High plateau length minus one |
| low_len | input | LEN_W (16) | Low plateau length minus one |
| high_code | input | DATA_W (14) | High plateau level |
| low_code | input | DATA_W (14) | Low plateau level |
| dac_code | output | DATA_W (14) | Registered DAC sample |
| rise_start | output | 1 | One-cycle marker on rising step 1 |

## Verification
The bench builds the block with its defaults: 14-bit codes, 16 steps per edge and 16-bit length fields. Keeping random plateau lengths under a dozen cycles lets thousands of cycles cover hundreds of complete periods. Those periods include zero-length plateaus, full-scale swings, level pairs closer than one step, and inverted level pairs. Inputs are also changed mid-period and enable is dropped mid-edge, which brings the sampling rule and the idle tracking of the low level within reach.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    SEG_IDLE = 3'd0,
    SEG_RISE = 3'd1,
    SEG_HIGH = 3'd2,
    SEG_FALL = 3'd3,
    SEG_LOW  = 3'd4
  } seg_e;
endpackage

// File: rtl/trap_seg_ctrl.sv
module trap_seg_ctrl
  import trap_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int STEPS  = 16,
  parameter int STEP_W = $clog2(STEPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  high_len_q,
  input  logic [LEN_W-1:0]  low_len_q,
  output seg_e              seg_q,
  output logic [STEP_W-1:0] step_q,
  output seg_e              seg_n,
  output logic [STEP_W-1:0] step_n,
  output logic              latch_ev
);
  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(STEPS);
  localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(1);

  logic [LEN_W-1:0] cnt_q, cnt_n;

  always_comb begin
    seg_n  = seg_q;
    step_n = step_q;
    cnt_n  = cnt_q;
    if (!enable) begin
      seg_n  = SEG_IDLE;
      step_n = '0;
      cnt_n  = '0;
    end else begin
      case (seg_q)
        SEG_IDLE: begin
          seg_n  = SEG_RISE;
          step_n = STEP_FIRST;
        end
        SEG_RISE: begin
          if (step_q == STEP_LAST) begin
            seg_n  = SEG_HIGH;
            step_n = '0;
            cnt_n  = high_len_q;
          end else begin
            step_n = step_q + STEP_FIRST;
          end
        end
        SEG_HIGH: begin
          if (cnt_q == '0) begin
            seg_n  = SEG_FALL;
            step_n = STEP_FIRST;
          end else begin
            cnt_n = cnt_q - LEN_W'(1);
          end
        end
        SEG_FALL: begin
          if (step_q == STEP_LAST) begin
            seg_n  = SEG_LOW;
            step_n = '0;
            cnt_n  = low_len_q;
          end else begin
            step_n = step_q + STEP_FIRST;
          end
        end
        SEG_LOW: begin
          if (cnt_q == '0) begin
            seg_n  = SEG_RISE;
            step_n = STEP_FIRST;
          end else begin
            cnt_n = cnt_q - LEN_W'(1);
          end
        end
        default: begin
          seg_n  = SEG_IDLE;
          step_n = '0;
          cnt_n  = '0;
        end
      endcase
    end
  end

  // a new period begins when the next segment is a rising edge entered from elsewhere
  assign latch_ev = (seg_n == SEG_RISE) && (seg_q != SEG_RISE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_IDLE;
      step_q <= '0;
      cnt_q  <= '0;
    end else begin
      seg_q  <= seg_n;
      step_q <= step_n;
      cnt_q  <= cnt_n;
    end
  end

  p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_RISE || seg_q == SEG_FALL) |-> (step_q >= STEP_FIRST && step_q <= STEP_LAST))
    else $error("step counter out of range");

  p_rise_to_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_RISE && step_q == STEP_LAST && enable) |=> (seg_q == SEG_HIGH))
    else $error("rising edge not followed by high plateau");

  p_high_to_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_HIGH && cnt_q == '0 && enable) |=> (seg_q == SEG_FALL && step_q == STEP_FIRST))
    else $error("high plateau not followed by falling edge");

  p_low_to_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_LOW && cnt_q == '0 && enable) |=> (seg_q == SEG_RISE && step_q == STEP_FIRST))
    else $error("low plateau not followed by rising edge");
endmodule

// File: rtl/trap_cfg_latch.sv
module trap_cfg_latch #(
  parameter int DATA_W = 14,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_ev,
  input  logic              idle_n,
  input  logic [LEN_W-1:0]  high_len,
  input  logic [LEN_W-1:0]  low_len,
  input  logic [DATA_W-1:0] high_code,
  input  logic [DATA_W-1:0] low_code,
  output logic [LEN_W-1:0]  hl_q,
  output logic [LEN_W-1:0]  ll_q,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_e,
  output logic [DATA_W-1:0] lo_e,
  output logic [DATA_W-1:0] base_e
);
  logic [DATA_W-1:0] base_q;

  // values in force for the sample being computed this cycle
  assign hi_e   = latch_ev ? high_code : hi_q;
  assign lo_e   = latch_ev ? low_code  : lo_q;
  assign base_e = latch_ev ? lo_q      : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q   <= '0;
      ll_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      base_q <= '0;
    end else if (latch_ev) begin
      hl_q   <= high_len;
      ll_q   <= low_len;
      hi_q   <= high_code;
      lo_q   <= low_code;
      base_q <= lo_q;
    end else if (idle_n) begin
      lo_q <= low_code;
    end
  end

  p_hold_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_ev && !idle_n) |=> ($stable(hi_q) && $stable(lo_q) && $stable(hl_q) && $stable(ll_q)))
    else $error("settings moved outside a period start");
endmodule

// File: rtl/trap_stair_out.sv
module trap_stair_out
  import trap_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int STEPS  = 16,
  parameter int STEP_W = $clog2(STEPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seg_e              seg_n,
  input  logic [STEP_W-1:0] step_n,
  input  logic              latch_ev,
  input  logic [DATA_W-1:0] hi_e,
  input  logic [DATA_W-1:0] lo_e,
  input  logic [DATA_W-1:0] base_e,
  input  logic [DATA_W-1:0] low_code,
  output logic [DATA_W-1:0] dac_q,
  output logic              mark_q
);
  localparam int PROD_W = DATA_W + STEP_W + 2;
  localparam logic signed [PROD_W-1:0] STEPS_S = PROD_W'(STEPS);

  function automatic logic [DATA_W-1:0] stair_code(
    input logic [DATA_W-1:0] from_c,
    input logic [DATA_W-1:0] to_c,
    input logic [STEP_W-1:0] k
  );
    logic signed [PROD_W-1:0] sa, sb, sk, q, s;
    sa = signed'({{(PROD_W-DATA_W){1'b0}}, from_c});
    sb = signed'({{(PROD_W-DATA_W){1'b0}}, to_c});
    sk = signed'({{(PROD_W-STEP_W){1'b0}}, k});
    q  = ((sb - sa) * sk) / STEPS_S;
    s  = sa + q;
    return s[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] dac_d;

  always_comb begin
    case (seg_n)
      SEG_RISE: dac_d = stair_code(base_e, hi_e, step_n);
      SEG_HIGH: dac_d = hi_e;
      SEG_FALL: dac_d = stair_code(hi_e, lo_e, step_n);
      SEG_LOW:  dac_d = lo_e;
      default:  dac_d = low_code;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= '0;
      mark_q <= 1'b0;
    end else begin
      dac_q  <= dac_d;
      mark_q <= latch_ev;
    end
  end
endmodule

// File: rtl/trap_edge_seq.sv
module trap_edge_seq
  import trap_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int LEN_W  = 16,
  parameter int STEPS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  high_len,
  input  logic [LEN_W-1:0]  low_len,
  input  logic [DATA_W-1:0] high_code,
  input  logic [DATA_W-1:0] low_code,
  output logic [DATA_W-1:0] dac_code,
  output logic              rise_start
);
  localparam int STEP_W = $clog2(STEPS) + 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS);

  seg_e              seg_q, seg_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              latch_ev;
  logic              idle_n;
  logic [LEN_W-1:0]  hl_q, ll_q;
  logic [DATA_W-1:0] hi_q, lo_q, hi_e, lo_e, base_e;

  assign idle_n = (seg_n == SEG_IDLE);

  trap_seg_ctrl #(.LEN_W(LEN_W), .STEPS(STEPS), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .high_len_q(hl_q), .low_len_q(ll_q),
    .seg_q(seg_q), .step_q(step_q), .seg_n(seg_n), .step_n(step_n),
    .latch_ev(latch_ev)
  );

  trap_cfg_latch #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .latch_ev(latch_ev), .idle_n(idle_n),
    .high_len(high_len), .low_len(low_len),
    .high_code(high_code), .low_code(low_code),
    .hl_q(hl_q), .ll_q(ll_q), .hi_q(hi_q), .lo_q(lo_q),
    .hi_e(hi_e), .lo_e(lo_e), .base_e(base_e)
  );

  trap_stair_out #(.DATA_W(DATA_W), .STEPS(STEPS), .STEP_W(STEP_W)) u_out (
    .clk(clk), .rst_n(rst_n), .seg_n(seg_n), .step_n(step_n),
    .latch_ev(latch_ev), .hi_e(hi_e), .lo_e(lo_e), .base_e(base_e),
    .low_code(low_code), .dac_q(dac_code), .mark_q(rise_start)
  );

  p_mark_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_start |-> (seg_q == SEG_RISE && step_q == STEP_W'(1)))
    else $error("marker outside rising step 1");

  p_rise_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_RISE && step_q == STEP_LAST) |-> (dac_code == hi_q))
    else $error("rising edge misses high level");

  p_fall_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_FALL && step_q == STEP_LAST) |-> (dac_code == lo_q))
    else $error("falling edge misses low level");

  p_high_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_HIGH) |-> (dac_code == hi_q))
    else $error("high plateau level wrong");

  p_low_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_LOW) |-> (dac_code == lo_q))
    else $error("low plateau level wrong");

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (dac_code == $past(low_code) && !rise_start))
    else $error("disabled output not parked on low level");
endmodule

// File: tb/trap_edge_seq_tb.sv
module trap_edge_seq_tb;
  localparam int DW = 14;
  localparam int LW = 16;
  localparam int ST = 16;
  localparam int CMAX = 1 << DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [LW-1:0] high_len = '0;
  logic [LW-1:0] low_len = '0;
  logic [DW-1:0] high_code = '0;
  logic [DW-1:0] low_code = DW'(500);
  logic [DW-1:0] dac_code;
  logic          rise_start;

  trap_edge_seq #(.DATA_W(DW), .LEN_W(LW), .STEPS(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .high_len(high_len), .low_len(low_len),
    .high_code(high_code), .low_code(low_code),
    .dac_code(dac_code), .rise_start(rise_start)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errs = 0;
  int    q_code[$];
  int    q_mark[$];
  string q_tag[$];
  int    exp_code, exp_mark;
  string exp_tag;
  bit    have_exp = 0;
  bit    changed = 0;
  bit    exp_changed = 0;
  bit    rand_on = 0;
  int    prev_lo = 0;
  int    cycles = 0;
  bit    done = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // staircase point k of STEPS, magnitude scaled then sign reapplied
  function automatic int stair(int from_c, int to_c, int k);
    int d, m;
    d = to_c - from_c;
    m = ((d < 0) ? -d : d) * k / ST;
    return (d < 0) ? from_c - m : from_c + m;
  endfunction

  task automatic build_period();
    int hi, lo, hl, ll;
    string rt;
    hi = int'(high_code); lo = int'(low_code);
    hl = int'(high_len);  ll = int'(low_len);
    rt = (hi < prev_lo) ? "R9" : "R4";
    for (int k = 1; k <= ST; k++) begin
      q_code.push_back(stair(prev_lo, hi, k));
      q_mark.push_back(k == 1 ? 1 : 0);
      q_tag.push_back(k == 1 ? "R1" : rt);
    end
    for (int i = 0; i <= hl; i++) begin
      q_code.push_back(hi); q_mark.push_back(0); q_tag.push_back("R2");
    end
    for (int k = 1; k <= ST; k++) begin
      q_code.push_back(stair(hi, lo, k)); q_mark.push_back(0);
      q_tag.push_back((lo > hi) ? "R9" : "R4");
    end
    for (int i = 0; i <= ll; i++) begin
      q_code.push_back(lo); q_mark.push_back(0); q_tag.push_back("R3");
    end
    prev_lo = lo;
    changed = 0;
  endtask

  task automatic randomize_inputs();
    high_code = DW'($urandom % CMAX);
    low_code  = DW'($urandom % CMAX);
    high_len  = LW'($urandom % 12);
    low_len   = LW'($urandom % 12);
  endtask

  // called at a negedge: prepares the expectation for the coming posedge
  task automatic step_model();
    if (q_code.size() == 0) build_period();
    else if (rand_on && ($urandom % 5 == 0)) begin
      randomize_inputs();
      changed = 1;
    end
    exp_code = q_code.pop_front();
    exp_mark = q_mark.pop_front();
    exp_tag  = q_tag.pop_front();
    exp_changed = changed;
    have_exp = 1;
  endtask

  task automatic check_pending();
    if (have_exp) begin
      check(exp_changed ? "R5" : exp_tag, "dac_code", int'(dac_code), exp_code);
      check("R6", "rise_start", int'(rise_start), exp_mark);
    end
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_pending();
      step_model();
    end
  endtask

  task automatic idle_for(int n);
    @(negedge clk);
    check_pending();
    enable = 1'b0;
    q_code.delete(); q_mark.delete(); q_tag.delete();
    have_exp = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R7", "idle dac_code", int'(dac_code), int'(low_code));
      check("R7", "idle rise_start", int'(rise_start), 0);
      if (i < n - 1) low_code = DW'($urandom % CMAX);
    end
    prev_lo = int'(low_code);
    enable = 1'b1;
    step_model();
  endtask

  initial begin
    void'($urandom(32'h5eed_7a11));
    repeat (3) @(negedge clk);
    check("R8", "reset dac_code", int'(dac_code), 0);
    check("R8", "reset rise_start", int'(rise_start), 0);
    rst_n = 1'b1;

    // directed: zero-length plateaus
    high_code = DW'(12000); low_code = DW'(1000); high_len = '0; low_len = '0;
    idle_for(4);
    run_cycles(120);

    // full scale swing with short plateaus
    high_code = DW'(CMAX - 1); low_code = '0; high_len = LW'(3); low_len = LW'(5);
    run_cycles(160);

    // inverted levels
    high_code = DW'(200); low_code = DW'(15000); high_len = LW'(2); low_len = LW'(1);
    run_cycles(160);

    // levels closer than one step, and equal levels
    high_code = DW'(15005); low_code = DW'(15000);
    run_cycles(120);
    high_code = DW'(777); low_code = DW'(777);
    run_cycles(80);

    // random settings changed at random points in the period
    rand_on = 1;
    run_cycles(3000);

    // drop enable mid-period, move low level while idle, resume
    idle_for(6);
    run_cycles(1500);
    idle_for(3);
    run_cycles(1500);

    @(negedge clk);
    check_pending();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule